// File: doc/BRIEF.md
# Packed Lane Shift Unit

This execution unit shifts the packed lanes of a 32-bit source operand. A 5-bit sub-operation code picks three things: the lane width (four bytes, two halfwords or one word), the kind of shift, and whether the shift amount comes from an immediate field or from the low bits of a second register operand. The shift kinds are left, saturating left, logical right, arithmetic right and rounding arithmetic right. Every lane is shifted on its own by the same amount. The lane results go back to the positions they came from.

An issue stage presents one operation per cycle with `valid_i` high. One clock later the unit returns the packed result, a write-enable, a request to set the overflow flag and a reserved-instruction indication. The register file, the flag storage and the pipeline around the unit are outside this block.

Top module: `lane_shift_unit`

## Requirements
- R1: The source splits into lanes of the selected width. Lane k occupies bits [k*W+W-1 : k*W]. Each lane is shifted independently by the same amount, and its result returns to the same bit positions.
- R2: Legal codes. Byte lanes: 0x00 left, 0x01 logical right, 0x04 arithmetic right, 0x05 rounding right. Halfword lanes: 0x08 left, 0x09 arithmetic right, 0x0C saturating left, 0x0D rounding right, 0x19 logical right. Word: 0x14 saturating left, 0x15 rounding right. Each of these codes with bit 1 also set takes the amount from `amt_reg_i[4:0]` instead of `imm_amt_i` and performs the same operation.
- R3: The amount is cut to its low 3 bits for byte lanes, its low 4 bits for halfword lanes and its low 5 bits for the word. A logical right shift fills with zeros. An arithmetic right shift fills with copies of the lane sign bit.
- R4: A rounding right shift by s adds 2^(s-1) to the sign-extended lane and then shifts it arithmetically by s. When s is 0 the lane passes through unchanged.
- R5: A saturating left shift returns the wrapped value while the result still fits in the signed lane. Otherwise it returns the signed maximum (positive lane) or the signed minimum (negative lane) and raises `ovf_set_o`.
- R6: A plain left shift keeps the wrapped low bits. It raises `ovf_set_o` when any 1 bit of any lane is shifted out.
- R7: The logical, arithmetic and rounding right shifts never raise `ovf_set_o`.
- R8: When `dest_idx_i` is 0 the operation is a no-op. `wr_en_o`, `ovf_set_o` and `illegal_o` stay low, and `res_o` keeps its value.
- R9: A code that R2 does not list, with a nonzero destination, raises `illegal_o`. It leaves `wr_en_o` and `ovf_set_o` low and `res_o` unchanged.
- R10: All outputs appear one clock after issue. A synchronous reset clears every output to 0. `res_o` holds its value in every cycle that has no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An operation is issued this cycle |
| subop_i | input | 5 | Sub-operation code |
| imm_amt_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 32 | Register operand; its low 5 bits give the amount in register forms |
| src_i | input | 32 | Packed source operand |
| dest_idx_i | input | 5 | Destination register index; 0 means no-op |
| res_o | output | 32 | Packed result, held between writes |
| wr_en_o | output | 1 | Write the result to the destination |
| ovf_set_o | output | 1 | Set the overflow flag |
| illegal_o | output | 1 | Reserved-instruction exception |

## Verification
Every legal code is run in both its immediate form and its register form. The sources hold the most negative value in every lane, a signed maximum, and mixed lane values, and the amounts are 0 and the largest value for the lane width. Sign-only patterns separate arithmetic from logical fill and show where saturation clamps. Amount 0 separates the rounding path from a plain shift. The largest amounts show whether the mask width matches each lane size. Register values carry junk above the mask bits, which catches masking at the wrong width or taking the amount from the wrong field. Constrained-random codes, destinations and operands then cover illegal codes, no-ops and flag behaviour against a lane-by-lane integer model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SHL_SAT = 3'd1,
    OP_SHRL    = 3'd2,
    OP_SHRA    = 3'd3,
    OP_SHRA_RND = 3'd4
  } shop_e;

  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2
  } lanew_e;

  typedef struct packed {
    logic   legal;
    logic   amt_from_reg;
    lanew_e lw;
    shop_e  op;
  } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [4:0] subop,
  output dec_t       dec
);
  always_comb begin
    dec.legal        = 1'b1;
    dec.amt_from_reg = subop[1];
    dec.lw           = LW_BYTE;
    dec.op           = OP_SHL;
    // bit 1 only picks the amount source, so decode with it cleared
    case ({subop[4:2], 1'b0, subop[0]})
      5'h00: begin dec.lw = LW_BYTE; dec.op = OP_SHL;      end
      5'h01: begin dec.lw = LW_BYTE; dec.op = OP_SHRL;     end
      5'h04: begin dec.lw = LW_BYTE; dec.op = OP_SHRA;     end
      5'h05: begin dec.lw = LW_BYTE; dec.op = OP_SHRA_RND; end
      5'h08: begin dec.lw = LW_HALF; dec.op = OP_SHL;      end
      5'h09: begin dec.lw = LW_HALF; dec.op = OP_SHRA;     end
      5'h0C: begin dec.lw = LW_HALF; dec.op = OP_SHL_SAT;  end
      5'h0D: begin dec.lw = LW_HALF; dec.op = OP_SHRA_RND; end
      5'h19: begin dec.lw = LW_HALF; dec.op = OP_SHRL;     end
      5'h14: begin dec.lw = LW_WORD; dec.op = OP_SHL_SAT;  end
      5'h15: begin dec.lw = LW_WORD; dec.op = OP_SHRA_RND; end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [SW-1:0] s,
  input  shop_e         op,
  output logic [W-1:0]  y,
  output logic          ovf
);
  logic [2*W-1:0] ush;   // zero-extended, shifted left
  logic [2*W-1:0] ssh;   // sign-extended, shifted left
  logic [W:0]     rinc;  // rounding increment 2^(s-1), 0 when s is 0
  logic [W:0]     rsum;
  logic [W:0]     rsh;
  logic           sat_ovf;

  always_comb begin
    ush     = {{W{1'b0}}, x} << s;
    ssh     = {{W{x[W-1]}}, x} << s;
    rinc    = ({{W{1'b0}}, 1'b1} << s) >> 1;
    rsum    = {x[W-1], x} + rinc;
    rsh     = $signed(rsum) >>> s;
    sat_ovf = !((&ssh[2*W-1:W-1]) || !(|ssh[2*W-1:W-1]));
    y   = ush[W-1:0];
    ovf = 1'b0;
    case (op)
      OP_SHL: begin
        y   = ush[W-1:0];
        ovf = |ush[2*W-1:W];
      end
      OP_SHL_SAT: begin
        ovf = sat_ovf;
        if (sat_ovf) y = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else         y = ssh[W-1:0];
      end
      OP_SHRL:     y = x >> s;
      OP_SHRA:     y = W'($signed(x) >>> s);
      OP_SHRA_RND: y = rsh[W-1:0];
      default:     y = x;
    endcase
  end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [4:0]        subop_i,
  input  logic [4:0]        imm_amt_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              ovf_set_o,
  output logic              illegal_o
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;
  localparam int NW = DATA_W / 32;

  dec_t              dec;
  logic [4:0]        amt;
  logic [DATA_W-1:0] res_b, res_h, res_w, lane_res;
  logic [NB-1:0]     ovf_b;
  logic [NH-1:0]     ovf_h;
  logic [NW-1:0]     ovf_w;
  logic              lane_ovf;
  logic              dest_live, do_write;
  logic              unused_amt_hi;

  lsu_decode u_dec (.subop(subop_i), .dec(dec));

  assign amt           = dec.amt_from_reg ? amt_reg_i[4:0] : imm_amt_i;
  assign unused_amt_hi = ^amt_reg_i[DATA_W-1:5];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    lsu_lane #(.W(8)) u_lane (
      .x(src_i[b*8 +: 8]), .s(amt[2:0]), .op(dec.op),
      .y(res_b[b*8 +: 8]), .ovf(ovf_b[b]));
  end
  for (genvar h = 0; h < NH; h++) begin : g_half
    lsu_lane #(.W(16)) u_lane (
      .x(src_i[h*16 +: 16]), .s(amt[3:0]), .op(dec.op),
      .y(res_h[h*16 +: 16]), .ovf(ovf_h[h]));
  end
  for (genvar w = 0; w < NW; w++) begin : g_word
    lsu_lane #(.W(32)) u_lane (
      .x(src_i[w*32 +: 32]), .s(amt[4:0]), .op(dec.op),
      .y(res_w[w*32 +: 32]), .ovf(ovf_w[w]));
  end

  always_comb begin
    case (dec.lw)
      LW_BYTE: begin lane_res = res_b; lane_ovf = |ovf_b; end
      LW_HALF: begin lane_res = res_h; lane_ovf = |ovf_h; end
      default: begin lane_res = res_w; lane_ovf = |ovf_w; end
    endcase
  end

  assign dest_live = |dest_idx_i;
  assign do_write  = valid_i && dest_live && dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      wr_en_o   <= 1'b0;
      ovf_set_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= do_write;
      ovf_set_o <= do_write && lane_ovf;
      illegal_o <= valid_i && dest_live && !dec.legal;
      if (do_write) res_o <= lane_res;
    end
  end
endmodule

// File: rtl/lane_shift_unit_chk.sv
module lane_shift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [4:0]        subop_i,
  input logic [4:0]        imm_amt_i,
  input logic [DATA_W-1:0] src_i,
  input logic [IDX_W-1:0]  dest_idx_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic              ovf_set_o,
  input logic              illegal_o
);
  assert_nop_dest0_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dest_idx_i == '0) |=> (!wr_en_o && !ovf_set_o && !illegal_o));

  assert_unknown_code_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dest_idx_i != '0 && subop_i == 5'h1F) |=> (illegal_o && !wr_en_o));

  assert_right_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && subop_i[0]) |=> !ovf_set_o);

  assert_flag_with_write_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_set_o |-> wr_en_o);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o));

  assert_zero_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dest_idx_i != '0 && subop_i == 5'h01 && imm_amt_i == 5'd0)
      |=> (res_o == $past(src_i)));
endmodule

bind lane_shift_unit lane_shift_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .subop_i(subop_i),
  .imm_amt_i(imm_amt_i), .src_i(src_i), .dest_idx_i(dest_idx_i),
  .res_o(res_o), .wr_en_o(wr_en_o), .ovf_set_o(ovf_set_o), .illegal_o(illegal_o));

// File: tb/lane_shift_unit_tb.sv
`timescale 1ns/1ps
module lane_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [4:0]  subop_i = '0;
  logic [4:0]  imm_amt_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic [31:0] src_i = '0;
  logic [4:0]  dest_idx_i = '0;
  logic [31:0] res_o;
  logic        wr_en_o, ovf_set_o, illegal_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;

  always #10 clk = ~clk;

  lane_shift_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .subop_i(subop_i),
    .imm_amt_i(imm_amt_i), .amt_reg_i(amt_reg_i), .src_i(src_i),
    .dest_idx_i(dest_idx_i), .res_o(res_o), .wr_en_o(wr_en_o),
    .ovf_set_o(ovf_set_o), .illegal_o(illegal_o));

  // op: 0 left, 1 sat left, 2 logical right, 3 arith right, 4 rounding, -1 illegal
  function automatic void decode_ref(input logic [4:0] so, output int op, output int w);
    op = -1; w = 8;
    case (so)
      5'h00, 5'h02: begin op = 0; w = 8;  end
      5'h01, 5'h03: begin op = 2; w = 8;  end
      5'h04, 5'h06: begin op = 3; w = 8;  end
      5'h05, 5'h07: begin op = 4; w = 8;  end
      5'h08, 5'h0A: begin op = 0; w = 16; end
      5'h09, 5'h0B: begin op = 3; w = 16; end
      5'h0C, 5'h0E: begin op = 1; w = 16; end
      5'h0D, 5'h0F: begin op = 4; w = 16; end
      5'h19, 5'h1B: begin op = 2; w = 16; end
      5'h14, 5'h16: begin op = 1; w = 32; end
      5'h15, 5'h17: begin op = 4; w = 32; end
      default: op = -1;
    endcase
  endfunction

  // returns {illegal, ovf, wr_en, result}
  function automatic logic [34:0] model(input logic [4:0] so, input logic [4:0] imm,
      input logic [31:0] ra, input logic [31:0] src, input logic [4:0] dst,
      input logic [31:0] prev);
    int op, w, s;
    longint mask, x, sv, y, lo, hi, p;
    logic [31:0] r;
    logic ov;
    decode_ref(so, op, w);
    if (dst == 5'd0) return {3'b000, prev};
    if (op < 0)      return {3'b100, prev};
    s = int'((so[1] ? ra[4:0] : imm)) & (w - 1);
    mask = (64'sd1 <<< w) - 1;
    lo = -(64'sd1 <<< (w - 1));
    hi = (64'sd1 <<< (w - 1)) - 1;
    r = '0; ov = 1'b0;
    for (int i = 0; i < 32 / w; i++) begin
      x  = longint'((src >> (i * w))) & mask;
      sv = (x > hi) ? x - (64'sd1 <<< w) : x;
      case (op)
        0: begin y = x <<< s; if ((y >>> w) != 0) ov = 1'b1; end
        1: begin
          p = sv * (64'sd1 <<< s);
          if (p > hi)      begin y = hi; ov = 1'b1; end
          else if (p < lo) begin y = lo; ov = 1'b1; end
          else y = p;
        end
        2: y = x >>> s;
        3: y = sv >>> s;
        default: y = (s == 0) ? x : ((sv + (64'sd1 <<< (s - 1))) >>> s);
      endcase
      r = r | 32'((y & mask) << (i * w));
    end
    return {1'b0, ov, 1'b1, r};
  endfunction

  function automatic string tag_of(input logic [4:0] so, input logic [4:0] dst);
    int op, w;
    decode_ref(so, op, w);
    if (dst == 5'd0) return "R8";
    case (op)
      -1: return "R9";
      0: return "R6";
      1: return "R5";
      4: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [34:0] act,
                       input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {ill,ovf,wr,res}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] so, input logic [4:0] imm, input logic [31:0] ra,
                     input logic [31:0] src, input logic [4:0] dst, input string tag);
    logic [34:0] exp, act;
    string t;
    @(negedge clk);
    valid_i = 1'b1; subop_i = so; imm_amt_i = imm; amt_reg_i = ra;
    src_i = src; dest_idx_i = dst;
    exp = model(so, imm, ra, src, dst, exp_res);
    @(posedge clk); #1;
    valid_i = 1'b0;
    act = {illegal_o, ovf_set_o, wr_en_o, res_o};
    t = (tag.len() != 0) ? tag : tag_of(so, dst);
    check(act === exp, t, act, exp);
    exp_res = exp[31:0];
  endtask

  task automatic idle_check();
    @(posedge clk); #1;
    check({illegal_o, ovf_set_o, wr_en_o, res_o} === {3'b000, exp_res}, "R10",
          {illegal_o, ovf_set_o, wr_en_o, res_o}, {3'b000, exp_res});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] legal [22] = '{5'h00,5'h01,5'h04,5'h05,5'h08,5'h09,5'h0C,5'h0D,5'h19,5'h14,5'h15,
                              5'h02,5'h03,5'h06,5'h07,5'h0A,5'h0B,5'h0E,5'h0F,5'h1B,5'h16,5'h17};
    logic [31:0] pats [6] = '{32'h80808080, 32'h80008000, 32'h80000000,
                              32'h7F7F7FFF, 32'h12345678, 32'hFFFF0001};
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    check({illegal_o, ovf_set_o, wr_en_o, res_o} === 35'd0, "R10 reset",
          {illegal_o, ovf_set_o, wr_en_o, res_o}, 35'd0);
    @(negedge clk); rst = 1'b0;

    // R1: byte lanes shifted independently and repacked (left by 1)
    run(5'h00, 5'd1, 32'h0, 32'h01807F02, 5'd3, "R1");
    // R2: register form takes amount from amt_reg_i low bits, immediate ignored
    run(5'h02, 5'd7, 32'hFFFFFFE1, 32'h01807F02, 5'd3, "R2");
    // R3: amount 9 on bytes masks to 1
    run(5'h01, 5'd9, 32'h0, 32'hF0F0F0F0, 5'd4, "R3");
    // R7: arithmetic right on most negative bytes raises no flag
    run(5'h04, 5'd7, 32'h0, 32'h80808080, 5'd4, "R7");
    // R4: rounding with amount 0 passes through
    run(5'h15, 5'd0, 32'h0, 32'h80000001, 5'd1, "R4");
    // R5: saturating halfword left clamps both ways
    run(5'h0C, 5'd4, 32'h0, 32'h7000_9000, 5'd2, "R5");
    // R8: destination 0 leaves the result
    run(5'h00, 5'd1, 32'h0, 32'hFFFFFFFF, 5'd0, "R8");
    // R9: unlisted code
    run(5'h1F, 5'd1, 32'h0, 32'h12345678, 5'd5, "R9");
    // R10: idle cycle holds the result
    idle_check();

    foreach (legal[i]) foreach (pats[j]) begin
      run(legal[i], 5'd0,  32'hFFFFFFE0, pats[j], 5'd7, "");
      run(legal[i], 5'd31, 32'hFFFFFFFF, pats[j], 5'd7, "");
    end

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] so, dst;
      so  = ($urandom % 4 == 0) ? 5'($urandom) : legal[$urandom % 22];
      dst = ($urandom % 10 == 0) ? 5'd0 : 5'($urandom % 31 + 1);
      run(so, 5'($urandom), $urandom, $urandom, dst, "");
      if (n % 100 == 0) idle_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule